// File: doc/BRIEF.md
# Push-pull two-wire bus master

This block is a memory-mapped master for a serial bus that has two wires and exactly one slave. Both lines are driven actively in both directions, so there are no pull-ups and no open-drain phases. Every access moves one register byte. Software loads a register address and, for a write, a data byte. It selects the direction and sets a start bit. The engine then runs the whole frame by itself:

- a start condition;
- the address byte with an even parity bit;
- the data byte with its parity bit, either driven out (write) or sampled from the slave (read);
- a stop condition.

No slave address is sent and there are no acknowledge bits. A read is a single access.

Each frame takes 40 half-periods of the bus clock, and one half-period lasts D system clock cycles, where D is the programmed divider. Completion, errors and a start request made while busy are reported in a write-1-to-clear status register. The interrupt line is the OR of the enabled status bits, gated by a global enable. Software can also abort a running frame, reset the block from a register write, and take manual control of either line.

Top module: `p2w_master`

## Requirements
- R1: After reset the registers read as follows: control (0x00) reads 0, clock control (0x04) reads 0x001, interrupt enable (0x08) reads 0 and status (0x0C) reads 0. Line control (0x24) reads 0x30, because both live line states are high. `irq` is low, `scl_o` and `sda_o` are high and `sda_oe` is high.
- R2: Writing control bit 7 while idle starts a frame. From the next cycle `scl_o` is high and `sda_o` is low for D cycles, which is the start condition. Control bit 7 reads 1 while the frame runs.
- R3: After the start condition come 18 bit slots, each a low half followed by a high half of D cycles. The slots carry the address byte MSB first, then its even parity bit (the XOR of the byte), then the data byte MSB first, then its parity bit. No acknowledge slot exists. The stop sequence follows: clock low with data going low, then clock high with data low, then data high. The frame lasts 40·D cycles in total.
- R4: D is clock-control bits [7:0]. A value of 0 acts as 1.
- R5: Clock-control bits [10:8] give a delay E. `sda_o` changes E cycles after the falling clock edge, with E clamped to D−1. Data never changes while the clock is high inside a bit slot.
- R6: Data-length bit 4 (0x18) set selects a read. During the nine data and parity slots `sda_oe` is 0 and `sda_o` is 1. `sda_i` is sampled on each rising clock edge, and the received byte is then readable at 0x1C.
- R7: In the cycle after the last one, the frame ends. Control bit 7 reads 0, and status bit 0 is set, unless a read parity error occurred.
- R8: A read whose received parity bit does not match sets status bit 1 and status bits [15:8] = 0x01. It does not set bit 0.
- R9: Writing control bit 7 during a frame sets status bit 2 and leaves the frame's waveform unchanged.
- R10: Writing control bit 6 during a frame returns both lines to idle in the next cycle. It also sets status bit 1 with status bits [15:8] = 0x02, and does not set bit 0.
- R11: Writing control bit 0 returns every register to its reset value and stops any frame.
- R12: Writing 1 to status bits [2:0] clears them, and clearing bit 1 also clears bits [15:8]. Writing 0 to a bit leaves it unchanged.
- R13: `irq` is high exactly when control bit 1 is set and any status bit [2:0] has its enable bit set in the interrupt enable register.
- R14: Line-control bit 0 forces the data line to the level in bit 1, with `sda_oe` high. Bit 2 forces the clock line to the level in bit 3. Bits 4 and 5 read back the live data and clock lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 6 | Register byte offset |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data, combinational on `cpu_addr` |
| scl_o | output | 1 | Bus clock line |
| sda_o | output | 1 | Bus data line, driven value |
| sda_oe | output | 1 | Data line drive enable |
| sda_i | input | 1 | Bus data line, sampled value |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach from the ports are the ones that overlap a running frame: a second start request, an abort, and a read whose parity bit is wrong. The bench reaches them by issuing register writes and reads part-way through a frame, at a chosen number of cycles after the start. It also plays the slave itself, driving `sda_i` cycle by cycle from its own frame model, and it can deliberately send a wrong parity bit. The same per-cycle model is checked against the lines on every clock with several divider and delay settings, including a divider of zero and a delay larger than the half-period.

// File: rtl/p2w_pkg.sv
package p2w_pkg;

  localparam int BYTE_W    = 8;
  localparam int DIV_W     = 8;
  localparam int DLY_W     = 3;
  localparam int SLOT_N    = 2 * (BYTE_W + 1);
  localparam int HALF_N    = 2 * SLOT_N + 4;
  localparam int HALF_W    = $clog2(HALF_N);
  localparam int SLOT_W    = $clog2(SLOT_N);
  localparam int RD_SLOT0  = BYTE_W + 1;
  localparam int H_BITS_LO = 1;
  localparam int H_BITS_HI = 2 * SLOT_N;
  localparam int H_STOP_LO = 2 * SLOT_N + 1;
  localparam int H_STOP_HI = 2 * SLOT_N + 2;

  localparam int OFS_CTL   = 'h00;
  localparam int OFS_CLK   = 'h04;
  localparam int OFS_IEN   = 'h08;
  localparam int OFS_IST   = 'h0C;
  localparam int OFS_RADDR = 'h10;
  localparam int OFS_XLEN  = 'h18;
  localparam int OFS_XDATA = 'h1C;
  localparam int OFS_LINE  = 'h24;

  localparam logic [7:0] ERRID_PARITY = 8'h01;
  localparam logic [7:0] ERRID_ABORT  = 8'h02;

  typedef struct packed {
    logic scl_lvl;
    logic scl_en;
    logic sda_lvl;
    logic sda_en;
  } line_ovr_t;

  function automatic logic even_par(input logic [BYTE_W-1:0] b);
    return ^b;
  endfunction

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  function automatic logic [DIV_W-1:0] eff_dly(input logic [DLY_W-1:0] dly,
                                               input logic [DIV_W-1:0] div_e);
    logic [DIV_W-1:0] wide;
    wide = DIV_W'(dly);
    return (wide >= div_e) ? div_e - DIV_W'(1) : wide;
  endfunction

endpackage

// File: rtl/p2w_timebase.sv
module p2w_timebase
  import p2w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              go,
  input  logic [DIV_W-1:0]  div_raw,
  output logic              active,
  output logic [HALF_W-1:0] half_idx,
  output logic [DIV_W-1:0]  hcnt,
  output logic              half_end,
  output logic              frame_end
);

  logic [DIV_W-1:0] div_q;

  assign half_end  = active && (hcnt == div_q - DIV_W'(1));
  assign frame_end = half_end && (half_idx == HALF_W'(HALF_N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      half_idx <= '0;
      hcnt     <= '0;
      div_q    <= DIV_W'(1);
    end else if (clr) begin
      active   <= 1'b0;
      half_idx <= '0;
      hcnt     <= '0;
    end else if (go && !active) begin
      active   <= 1'b1;
      half_idx <= '0;
      hcnt     <= '0;
      div_q    <= eff_div(div_raw);
    end else if (active) begin
      if (half_end) begin
        hcnt <= '0;
        if (frame_end) begin
          active   <= 1'b0;
          half_idx <= '0;
        end else begin
          half_idx <= half_idx + HALF_W'(1);
        end
      end else begin
        hcnt <= hcnt + DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/p2w_frame.sv
module p2w_frame
  import p2w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              go,
  input  logic              active,
  input  logic [HALF_W-1:0] half_idx,
  input  logic [DIV_W-1:0]  hcnt,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic [BYTE_W-1:0] data_byte,
  input  logic              is_read,
  input  logic [DIV_W-1:0]  div_raw,
  input  logic [DLY_W-1:0]  dly_raw,
  input  logic              sda_in,
  output logic              scl_eng,
  output logic              sda_eng,
  output logic              oe_eng,
  output logic              rd_mode,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_bad,
  output logic              in_bits,
  output logic              sample_evt
);

  logic [SLOT_N-1:0] frame_q;
  logic [DIV_W-1:0]  dly_q;
  logic [BYTE_W:0]   rx_q;
  logic              sda_hold;
  logic [HALF_W-1:0] hm1;
  logic [SLOT_W-1:0] slot;
  logic              low_half;
  logic              rd_slot;
  logic              tx_bit;

  assign hm1      = half_idx - HALF_W'(1);
  assign slot     = SLOT_W'(hm1 >> 1);
  assign low_half = ~hm1[0];
  assign in_bits  = active && (half_idx >= HALF_W'(H_BITS_LO)) &&
                    (half_idx <= HALF_W'(H_BITS_HI));
  assign rd_slot  = rd_mode && (slot >= SLOT_W'(RD_SLOT0));
  assign tx_bit   = frame_q[SLOT_W'(SLOT_N - 1) - slot];

  assign sample_evt = in_bits && rd_slot && !low_half && (hcnt == '0);
  assign rx_byte    = rx_q[BYTE_W:1];
  assign rx_bad     = ^rx_q;

  always_comb begin
    scl_eng = 1'b1;
    oe_eng  = 1'b1;
    sda_eng = sda_hold;
    if (!active) begin
      sda_eng = 1'b1;
    end else if (half_idx == '0) begin
      sda_eng = 1'b0;
    end else if (in_bits) begin
      scl_eng = ~low_half;
      if (rd_slot) begin
        oe_eng  = 1'b0;
        sda_eng = 1'b1;
      end else if (low_half && (hcnt >= dly_q)) begin
        sda_eng = tx_bit;
      end
    end else if (half_idx == HALF_W'(H_STOP_LO)) begin
      scl_eng = 1'b0;
      if (hcnt >= dly_q) sda_eng = 1'b0;
    end else if (half_idx == HALF_W'(H_STOP_HI)) begin
      sda_eng = 1'b0;
    end else begin
      sda_eng = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q  <= '0;
      dly_q    <= '0;
      rd_mode  <= 1'b0;
      rx_q     <= '0;
      sda_hold <= 1'b1;
    end else begin
      sda_hold <= clr ? 1'b1 : sda_eng;
      if (go && !active && !clr) begin
        frame_q <= {addr_byte, even_par(addr_byte), data_byte, even_par(data_byte)};
        dly_q   <= eff_dly(dly_raw, eff_div(div_raw));
        rd_mode <= is_read;
        rx_q    <= '0;
      end else if (sample_evt) begin
        rx_q <= {rx_q[BYTE_W-1:0], sda_in};
      end
    end
  end

endmodule

// File: rtl/p2w_regfile.sv
module p2w_regfile
  import p2w_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              busy,
  input  logic              evt_done,
  input  logic              evt_perr,
  input  logic              evt_abort,
  input  logic              evt_lwb,
  input  logic              rx_load,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              sda_live,
  input  logic              scl_live,
  output logic              start_req,
  output logic              abort_req,
  output logic              srst,
  output logic              gie,
  output logic [2:0]        ist_bits,
  output logic [DIV_W-1:0]  div_raw,
  output logic [DLY_W-1:0]  dly_raw,
  output logic [BYTE_W-1:0] raddr,
  output logic [BYTE_W-1:0] xdata,
  output logic              rd_dir,
  output line_ovr_t         ovr,
  output logic              irq
);

  logic [2:0]        ien_q;
  logic [7:0]        errid_q;
  logic [2:0]        cnt_q;
  logic [2:0]        w1c;
  logic [2:0]        ist_set;

  function automatic logic hit(input logic we, input logic [ADDR_W-1:0] a, input int ofs);
    return we && (a == ADDR_W'(ofs));
  endfunction

  assign start_req = hit(cpu_we, cpu_addr, OFS_CTL) && cpu_wdata[7];
  assign abort_req = hit(cpu_we, cpu_addr, OFS_CTL) && cpu_wdata[6];
  assign srst      = hit(cpu_we, cpu_addr, OFS_CTL) && cpu_wdata[0];
  assign w1c       = hit(cpu_we, cpu_addr, OFS_IST) ? cpu_wdata[2:0] : 3'b000;
  assign ist_set   = {evt_lwb, evt_perr | evt_abort, evt_done};
  assign irq       = gie && |(ist_bits & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie      <= 1'b0;
      ien_q    <= '0;
      ist_bits <= '0;
      errid_q  <= '0;
      div_raw  <= DIV_W'(1);
      dly_raw  <= '0;
      raddr    <= '0;
      xdata    <= '0;
      rd_dir   <= 1'b0;
      cnt_q    <= '0;
      ovr      <= '0;
    end else if (srst) begin
      gie      <= 1'b0;
      ien_q    <= '0;
      ist_bits <= '0;
      errid_q  <= '0;
      div_raw  <= DIV_W'(1);
      dly_raw  <= '0;
      raddr    <= '0;
      xdata    <= '0;
      rd_dir   <= 1'b0;
      cnt_q    <= '0;
      ovr      <= '0;
    end else begin
      ist_bits <= (ist_bits & ~w1c) | ist_set;
      if (evt_perr)       errid_q <= ERRID_PARITY;
      else if (evt_abort) errid_q <= ERRID_ABORT;
      else if (w1c[1])    errid_q <= '0;
      if (hit(cpu_we, cpu_addr, OFS_CTL)) gie <= cpu_wdata[1];
      if (hit(cpu_we, cpu_addr, OFS_IEN)) ien_q <= cpu_wdata[2:0];
      if (hit(cpu_we, cpu_addr, OFS_CLK)) begin
        div_raw <= cpu_wdata[DIV_W-1:0];
        dly_raw <= cpu_wdata[DIV_W+DLY_W-1:DIV_W];
      end
      if (hit(cpu_we, cpu_addr, OFS_RADDR)) raddr <= cpu_wdata[BYTE_W-1:0];
      if (hit(cpu_we, cpu_addr, OFS_XLEN)) begin
        rd_dir <= cpu_wdata[4];
        cnt_q  <= cpu_wdata[2:0];
      end
      if (rx_load)                               xdata <= rx_byte;
      else if (hit(cpu_we, cpu_addr, OFS_XDATA)) xdata <= cpu_wdata[BYTE_W-1:0];
      if (hit(cpu_we, cpu_addr, OFS_LINE)) ovr <= line_ovr_t'(cpu_wdata[3:0]);
    end
  end

  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      ADDR_W'(OFS_CTL):   cpu_rdata[7:0] = {busy, 5'b0, gie, 1'b0};
      ADDR_W'(OFS_CLK):   cpu_rdata[DIV_W+DLY_W-1:0] = {dly_raw, div_raw};
      ADDR_W'(OFS_IEN):   cpu_rdata[2:0] = ien_q;
      ADDR_W'(OFS_IST):   cpu_rdata[15:0] = {errid_q, 5'b0, ist_bits};
      ADDR_W'(OFS_RADDR): cpu_rdata[BYTE_W-1:0] = raddr;
      ADDR_W'(OFS_XLEN):  cpu_rdata[4:0] = {rd_dir, 1'b0, cnt_q};
      ADDR_W'(OFS_XDATA): cpu_rdata[BYTE_W-1:0] = xdata;
      ADDR_W'(OFS_LINE):  cpu_rdata[5:0] = {scl_live, sda_live, ovr};
      default:            cpu_rdata = '0;
    endcase
  end

endmodule

// File: rtl/p2w_master.sv
module p2w_master
  import p2w_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              scl_o,
  output logic              sda_o,
  output logic              sda_oe,
  input  logic              sda_i,
  output logic              irq
);

  logic              busy, accept, clr;
  logic              start_req, abort_req, srst, gie;
  logic [2:0]        ist_bits;
  logic [DIV_W-1:0]  div_raw, hcnt;
  logic [DLY_W-1:0]  dly_raw;
  logic [BYTE_W-1:0] raddr, xdata, rx_byte;
  logic              rd_dir, rd_mode, rx_bad;
  line_ovr_t         ovr;
  logic [HALF_W-1:0] half_idx;
  logic              half_end, frame_end, in_bits, sample_evt;
  logic              scl_eng, sda_eng, oe_eng;
  logic              evt_done, evt_perr, evt_abort, evt_lwb, rx_load;
  logic              ovr_any, sda_live;

  assign accept    = start_req && !busy && !abort_req && !srst;
  assign clr       = srst || (abort_req && busy);
  assign evt_abort = abort_req && busy && !srst;
  assign evt_lwb   = start_req && busy && !srst;
  assign evt_done  = frame_end && !clr && !(rd_mode && rx_bad);
  assign evt_perr  = frame_end && !clr && rd_mode && rx_bad;
  assign rx_load   = frame_end && !clr && rd_mode;

  assign scl_o    = ovr.scl_en ? ovr.scl_lvl : scl_eng;
  assign sda_o    = ovr.sda_en ? ovr.sda_lvl : sda_eng;
  assign sda_oe   = ovr.sda_en | oe_eng;
  assign sda_live = sda_oe ? sda_o : sda_i;
  assign ovr_any  = ovr.scl_en | ovr.sda_en;

  p2w_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .busy(busy), .evt_done(evt_done), .evt_perr(evt_perr), .evt_abort(evt_abort),
    .evt_lwb(evt_lwb), .rx_load(rx_load), .rx_byte(rx_byte),
    .sda_live(sda_live), .scl_live(scl_o),
    .start_req(start_req), .abort_req(abort_req), .srst(srst), .gie(gie),
    .ist_bits(ist_bits), .div_raw(div_raw), .dly_raw(dly_raw),
    .raddr(raddr), .xdata(xdata), .rd_dir(rd_dir), .ovr(ovr), .irq(irq)
  );

  p2w_timebase u_tb (
    .clk(clk), .rst_n(rst_n), .clr(clr), .go(accept), .div_raw(div_raw),
    .active(busy), .half_idx(half_idx), .hcnt(hcnt),
    .half_end(half_end), .frame_end(frame_end)
  );

  p2w_frame u_frame (
    .clk(clk), .rst_n(rst_n), .clr(clr), .go(accept), .active(busy),
    .half_idx(half_idx), .hcnt(hcnt), .addr_byte(raddr), .data_byte(xdata),
    .is_read(rd_dir), .div_raw(div_raw), .dly_raw(dly_raw), .sda_in(sda_i),
    .scl_eng(scl_eng), .sda_eng(sda_eng), .oe_eng(oe_eng), .rd_mode(rd_mode),
    .rx_byte(rx_byte), .rx_bad(rx_bad), .in_bits(in_bits), .sample_evt(sample_evt)
  );

endmodule

// File: rtl/p2w_checker.sv
module p2w_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       accept,
  input logic       start_req,
  input logic       abort_req,
  input logic       srst,
  input logic       frame_end,
  input logic       sample_evt,
  input logic       in_bits,
  input logic [2:0] ist_bits,
  input logic       gie,
  input logic       irq,
  input logic       scl_o,
  input logic       sda_o,
  input logic       sda_oe,
  input logic       ovr_any
);

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ovr_any) |-> (scl_o && sda_o && sda_oe)); // R1

  AST_START_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ovr_any) |=> (busy && scl_o && !sda_o)); // R2

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bits && $past(in_bits) && scl_o && $past(scl_o) && !ovr_any && !$past(ovr_any))
      |-> $stable(sda_o)); // R5

  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && !ovr_any) |-> (!sda_oe && scl_o)); // R6

  AST_END_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !srst && !abort_req) |=> !busy); // R7

  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && busy && !srst) |=> ist_bits[2]); // R9

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req && busy && !srst) |=> (!busy && ist_bits[1])); // R10

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!busy && (ist_bits == 3'b000) && !gie)); // R11

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq); // R13

endmodule

bind p2w_master p2w_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .accept(accept), .start_req(start_req),
  .abort_req(abort_req), .srst(srst), .frame_end(frame_end), .sample_evt(sample_evt),
  .in_bits(in_bits), .ist_bits(ist_bits), .gie(gie), .irq(irq),
  .scl_o(scl_o), .sda_o(sda_o), .sda_oe(sda_oe), .ovr_any(ovr_any)
);

// File: tb/tb_p2w_master.sv
`timescale 1ns/1ps
module tb_p2w_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [5:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        scl_o, sda_o, sda_oe, irq;
  logic        sda_i = 1'b1;

  int checks = 0;
  int failures = 0;
  bit ovr_on = 1'b0;
  bit done_flag = 1'b0;
  string cur_tag = "R3";
  bit q_scl[$], q_sda[$], q_oe[$], q_din[$];

  always #5 clk = ~clk;

  p2w_master dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .scl_o(scl_o), .sda_o(sda_o),
    .sda_oe(sda_oe), .sda_i(sda_i), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Per-cycle line comparison against the reference queue (R3, R5, R6)
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      bit es, ed, eo;
      if (q_scl.size() > 0) begin
        es = q_scl.pop_front();
        ed = q_sda.pop_front();
        eo = q_oe.pop_front();
        sda_i = q_din.pop_front();
        chk(cur_tag, {29'd0, scl_o, sda_o, sda_oe}, {29'd0, es, ed, eo});
      end else begin
        sda_i = 1'b1;
        if (!ovr_on) chk("R1 idle lines", {29'd0, scl_o, sda_o, sda_oe}, 32'd7);
      end
    end
  end

  task automatic push_frame(input logic [7:0] a, input logic [7:0] d, input bit rd,
                            input logic [7:0] rb, input bit rp, input int divr, input int dlyr);
    int dd, ee, h, hc, s;
    bit bits[18];
    bit prev, e_scl, e_sda, e_oe, e_din, low;
    dd = (divr == 0) ? 1 : divr;
    ee = (dlyr >= dd) ? dd - 1 : dlyr;
    for (int i = 0; i < 8; i++) begin
      bits[i] = a[7-i];
      bits[9+i] = rd ? rb[7-i] : d[7-i];
    end
    bits[8] = ^a;
    bits[17] = rd ? rp : ^d;
    prev = 1'b1;
    for (int k = 0; k < 40 * dd; k++) begin
      h = k / dd; hc = k % dd;
      e_scl = 1'b1; e_oe = 1'b1; e_din = 1'b1; e_sda = prev;
      if (h == 0) e_sda = 1'b0;
      else if (h <= 36) begin
        s = (h - 1) / 2;
        low = ((h - 1) % 2) == 0;
        e_scl = !low;
        if (rd && s >= 9) begin
          e_oe = 1'b0; e_sda = 1'b1; e_din = bits[s];
        end else if (low && hc >= ee) e_sda = bits[s];
      end else if (h == 37) begin
        e_scl = 1'b0;
        if (hc >= ee) e_sda = 1'b0;
      end else if (h == 38) e_sda = 1'b0;
      else e_sda = 1'b1;
      prev = e_sda;
      q_scl.push_back(e_scl); q_sda.push_back(e_sda);
      q_oe.push_back(e_oe);   q_din.push_back(e_din);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    #1 cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk);
    #1 cpu_we = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    #2 cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic start_frame(input logic [7:0] a, input logic [7:0] d, input bit rd,
                             input logic [7:0] rb, input bit rp, input int divr, input int dlyr);
    reg_write(6'h04, {21'd0, 3'(dlyr), 8'(divr)});
    reg_write(6'h10, {24'd0, a});
    reg_write(6'h1C, {24'd0, d});
    reg_write(6'h18, {27'd0, rd, 4'd0});
    @(negedge clk);
    #1 cpu_we = 1'b1; cpu_addr = 6'h00; cpu_wdata = 32'h82;
    @(posedge clk);
    #1 cpu_we = 1'b0;
    push_frame(a, d, rd, rb, rp, divr, dlyr);
  endtask

  task automatic wait_idle();
    while (q_scl.size() > 0) begin @(negedge clk); #1; end
    @(negedge clk); #1;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    reg_read(6'h00, v); chk("R1 ctl", v, 32'h0);
    reg_read(6'h04, v); chk("R1 clkcfg", v, 32'h001);
    reg_read(6'h08, v); chk("R1 ien", v, 32'h0);
    reg_read(6'h0C, v); chk("R1 ist", v, 32'h0);
    reg_read(6'h24, v); chk("R1 line", v, 32'h30);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 R3 R5 R9: write frame, div 2 delay 1, start requested again mid-frame
    reg_write(6'h08, 32'h7);
    cur_tag = "R3 R5 write frame";
    start_frame(8'hA5, 8'h3C, 1'b0, 8'h00, 1'b0, 2, 1);
    repeat (10) @(negedge clk);
    reg_read(6'h00, v); chk("R2 busy bit", v, 32'h82);
    cur_tag = "R9 frame unchanged";
    reg_write(6'h00, 32'h82);
    wait_idle();
    reg_read(6'h00, v); chk("R7 busy clear", v, 32'h02);
    reg_read(6'h0C, v); chk("R7 R9 ist", v, 32'h5);
    chk("R13 irq on", {31'd0, irq}, 32'd1);
    reg_write(6'h0C, 32'h4);
    reg_read(6'h0C, v); chk("R12 w1c bit2", v, 32'h1);
    reg_write(6'h0C, 32'h0);
    reg_read(6'h0C, v); chk("R12 zero write", v, 32'h1);
    reg_write(6'h0C, 32'h1);
    reg_read(6'h0C, v); chk("R12 w1c bit0", v, 32'h0);

    // R4: divider 0 acts as 1, delay clamped to 0
    cur_tag = "R4 div zero";
    start_frame(8'hFF, 8'h81, 1'b0, 8'h00, 1'b0, 0, 3);
    wait_idle();
    reg_read(6'h0C, v); chk("R4 ist done", v, 32'h1);
    reg_write(6'h0C, 32'h7);

    // R6: read with good parity, div 3 delay 2
    cur_tag = "R6 read frame";
    start_frame(8'h12, 8'h00, 1'b1, 8'h5A, 1'b0, 3, 2);
    wait_idle();
    reg_read(6'h1C, v); chk("R6 rx byte", v, 32'h5A);
    reg_read(6'h0C, v); chk("R6 ist done", v, 32'h1);
    reg_write(6'h0C, 32'h7);

    // R8: read with wrong parity, delay 7 clamped to 1
    cur_tag = "R8 R5 read bad parity";
    start_frame(8'h3E, 8'h00, 1'b1, 8'h77, 1'b1, 2, 7);
    wait_idle();
    reg_read(6'h0C, v); chk("R8 ist err", v, 32'h0102);
    reg_read(6'h1C, v); chk("R6 rx byte 2", v, 32'h77);
    chk("R13 irq err", {31'd0, irq}, 32'd1);
    reg_write(6'h00, 32'h0);
    chk("R13 irq gated", {31'd0, irq}, 32'd0);
    reg_write(6'h0C, 32'h2);
    reg_read(6'h0C, v); chk("R12 errid cleared", v, 32'h0);

    // R10: abort mid-frame
    cur_tag = "R10 pre-abort";
    start_frame(8'hC3, 8'h18, 1'b0, 8'h00, 1'b0, 2, 0);
    repeat (20) @(negedge clk);
    @(negedge clk);
    #1 cpu_we = 1'b1; cpu_addr = 6'h00; cpu_wdata = 32'h40;
    @(posedge clk);
    #1 cpu_we = 1'b0;
    q_scl.delete(); q_sda.delete(); q_oe.delete(); q_din.delete();
    @(negedge clk); #1;
    reg_read(6'h0C, v); chk("R10 ist abort", v, 32'h0202);
    reg_read(6'h00, v); chk("R10 ctl idle", v, 32'h0);
    reg_write(6'h0C, 32'h7);

    // R14: manual line control
    ovr_on = 1'b1;
    reg_write(6'h24, 32'h05);
    @(negedge clk); #1;
    chk("R14 forced low", {29'd0, scl_o, sda_o, sda_oe}, 32'd1);
    reg_read(6'h24, v); chk("R14 readback low", v, 32'h05);
    reg_write(6'h24, 32'h0F);
    reg_read(6'h24, v); chk("R14 readback high", v, 32'h3F);
    reg_write(6'h24, 32'h01);
    reg_read(6'h24, v); chk("R14 sda only", v, 32'h21);
    reg_write(6'h24, 32'h00);
    ovr_on = 1'b0;

    // R11: soft reset
    reg_write(6'h04, 32'h305);
    reg_write(6'h08, 32'h7);
    reg_write(6'h24, 32'h0C);
    ovr_on = 1'b1;
    reg_write(6'h00, 32'h03);
    ovr_on = 1'b0;
    reg_read(6'h04, v); chk("R11 clkcfg", v, 32'h001);
    reg_read(6'h08, v); chk("R11 ien", v, 32'h0);
    reg_read(6'h00, v); chk("R11 ctl", v, 32'h0);
    reg_read(6'h24, v); chk("R11 line", v, 32'h30);

    repeat (3) @(negedge clk);
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule